// File: doc/BRIEF.md
# Debug Memory-Access Sequencer

This block turns single 32-bit memory reads and writes into the ordered series of debug-link register transfers that a two-wire debug port needs. A transfer engine underneath handles the bit-level link. The sequencer only chooses each transfer's target (debug port or access port), its direction, its two-bit register address and its write word, and then reacts to the acknowledge code that comes back.

A memory write programs the access port's address register and then writes its data register. Access-port reads are posted: each one returns the result of the previous read. So a memory read programs the address register, reads the data register to start the bus access and throws that returned word away, and then reads the debug port's read buffer to get the real data. Before any access-port traffic, the debug port's bank-select register must hold the right bank. The sequencer caches the last value it wrote and skips the rewrite when that value still holds.

A WAIT acknowledge repeats the same transfer, up to a limit set at a port. A FAULT acknowledge makes the sequencer write the sticky-flag clear word to the abort register and then report an error.

Top module: `dbg_mem_seq`

## Requirements
- R1: After reset `mem_ready` is 1 and `xf_req` and `rsp_valid` are 0. `mem_ready` is 1 only while no request is in progress, and a request is taken when `mem_valid` and `mem_ready` are both 1 at a clock edge.
- R2: A read issues, in order, an access-port write to address 01 carrying `mem_addr`, an access-port read of address 11, and a debug-port read of address 11. `rsp_rdata` equals the word returned by that last transfer, and the word returned by the access-port read is discarded.
- R3: A write issues an access-port write to address 01 carrying `mem_addr`, then an access-port write to address 11 carrying `mem_wdata` unchanged (bits 7:0 are the byte at the lowest address). No read-buffer transfer follows.
- R4: The first request after reset, and the first request after any FAULT, starts with a debug-port write to address 10 of the select word (AP number in bits 31:24, bank in bits 7:4, all other bits 0; with default parameters the word is 0). While the cached value still holds, later requests skip this transfer.
- R5: Acknowledge codes on `xf_ack` are OK=001, WAIT=010 and FAULT=100. On WAIT the same transfer is reissued with identical fields. Up to `retry_limit` WAITs on one transfer are tolerated, and then the sequence continues.
- R6: A WAIT on the (`retry_limit`+1)-th attempt of one transfer ends the request with `rsp_err`=01. No further transfer is issued for that request.
- R7: A FAULT acknowledge, or any code other than OK or WAIT, is followed by a debug-port write to address 00 of 0x0000001E. Its own acknowledge is ignored, and the request ends with `rsp_err`=10.
- R8: While `xf_req` is 1 and `xf_done` has not been seen, `xf_ap`, `xf_rnw`, `xf_addr` and `xf_wdata` stay stable.
- R9: `rsp_valid` pulses for one cycle, in the cycle after the edge that samples the last transfer's `xf_done`, and `mem_ready` returns in the next cycle. A successful request reports `rsp_err`=00. `rsp_rdata` is 0 for writes and for failed requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retry_limit | input | RETRY_W | WAIT acknowledges tolerated per transfer |
| mem_valid | input | 1 | Memory request present |
| mem_ready | output | 1 | Sequencer idle, request can be taken |
| mem_write | input | 1 | 1 = write, 0 = read |
| mem_addr | input | 32 | Target byte address |
| mem_wdata | input | 32 | Write word |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 2 | 00 ok, 01 WAIT timeout, 10 fault |
| rsp_rdata | output | 32 | Read result |
| xf_req | output | 1 | Transfer request to the engine |
| xf_ap | output | 1 | 1 = access port, 0 = debug port |
| xf_rnw | output | 1 | 1 = read, 0 = write |
| xf_addr | output | 2 | Register address bits 3:2 |
| xf_wdata | output | 32 | Transfer write word |
| xf_done | input | 1 | Engine finished the transfer (one cycle) |
| xf_ack | input | 3 | Acknowledge code of the finished transfer |
| xf_rdata | input | 32 | Word read by the finished transfer |

## Verification
Each transfer's fields are visible in the cycle after the edge that took the request or sampled the previous `xf_done`. The bench's engine model records them at the falling edge of the first cycle in which `xf_req` is high. It also checks that they stay the same on every falling edge until it raises `xf_done`. The response is due exactly one cycle after the edge that samples the final `xf_done`. The bench waits for `rsp_valid` at falling edges and then checks, one falling edge later, that the pulse has ended and `mem_ready` is back. Every transfer list is compared, entry by entry, against a list that bench functions build from the request type, whether a select write is due, and the scripted acknowledges.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

  localparam int WORD_W = 32;

  // acknowledge codes as delivered by the transfer engine
  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  // two-bit register addresses used in transfer headers
  localparam logic [1:0] RA_ADDR_REG = 2'b01; // access port, address register
  localparam logic [1:0] RA_DATA_REG = 2'b11; // access port, data register
  localparam logic [1:0] RA_RD_BUF   = 2'b11; // debug port, read buffer
  localparam logic [1:0] RA_BANK_SEL = 2'b10; // debug port, bank select (write)
  localparam logic [1:0] RA_ABORT    = 2'b00; // debug port, abort (write)

  typedef enum logic [2:0] {
    STP_IDLE,
    STP_SEL,
    STP_TAR,
    STP_DRW,
    STP_RDBUF,
    STP_ABORT,
    STP_RESP
  } step_e;

  typedef enum logic [1:0] {
    RES_OK      = 2'b00,
    RES_TIMEOUT = 2'b01,
    RES_FAULT   = 2'b10
  } res_e;

  typedef struct packed {
    logic              ap;
    logic              rnw;
    logic [1:0]        a;
    logic [WORD_W-1:0] wdata;
  } xfer_t;

  function automatic logic [WORD_W-1:0] select_word(logic [7:0] ap_num, logic [3:0] bank);
    logic [WORD_W-1:0] w;
    w = '0;
    w[31:24] = ap_num;
    w[7:4]   = bank;
    return w;
  endfunction

  // sticky compare, sticky error, write-data error and overrun clear bits
  function automatic logic [WORD_W-1:0] abort_clear_word();
    logic [WORD_W-1:0] w;
    w = '0;
    for (int b = 1; b <= 4; b++) w[b] = 1'b1;
    return w;
  endfunction

  function automatic xfer_t build_xfer(step_e st, logic wr, logic [WORD_W-1:0] addr,
                                       logic [WORD_W-1:0] wdata, logic [WORD_W-1:0] sel);
    xfer_t x;
    x = '0;
    case (st)
      STP_SEL:   begin x.ap = 1'b0; x.rnw = 1'b0; x.a = RA_BANK_SEL; x.wdata = sel; end
      STP_TAR:   begin x.ap = 1'b1; x.rnw = 1'b0; x.a = RA_ADDR_REG; x.wdata = addr; end
      STP_DRW:   begin x.ap = 1'b1; x.rnw = !wr; x.a = RA_DATA_REG; x.wdata = wr ? wdata : '0; end
      STP_RDBUF: begin x.ap = 1'b0; x.rnw = 1'b1; x.a = RA_RD_BUF; x.wdata = '0; end
      STP_ABORT: begin x.ap = 1'b0; x.rnw = 1'b0; x.a = RA_ABORT; x.wdata = abort_clear_word(); end
      default:   x = '0;
    endcase
    return x;
  endfunction

  function automatic step_e step_after_ok(step_e st, logic wr);
    case (st)
      STP_SEL:   return STP_TAR;
      STP_TAR:   return STP_DRW;
      STP_DRW:   return wr ? STP_RESP : STP_RDBUF;
      default:   return STP_RESP;
    endcase
  endfunction

endpackage

// File: rtl/dbg_seq_retry.sv
module dbg_seq_retry #(
  parameter int RETRY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               wait_seen,
  input  logic [RETRY_W-1:0] limit,
  output logic               exhausted,
  output logic [RETRY_W-1:0] count
);

  assign exhausted = wait_seen && (count == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     count <= '0;
    else if (clear)                 count <= '0;
    else if (wait_seen && !exhausted) count <= count + 1'b1;
  end

  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |-> count <= limit) else $error("retry count above limit"); // R5

endmodule

// File: rtl/dbg_seq_bank_cache.sv
module dbg_seq_bank_cache #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store,
  input  logic              drop,
  input  logic [WORD_W-1:0] want,
  output logic              hit
);

  logic              held_valid;
  logic [WORD_W-1:0] held_word;

  assign hit = held_valid && (held_word == want);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_valid <= 1'b0;
      held_word  <= '0;
    end else if (drop) begin
      held_valid <= 1'b0;
    end else if (store) begin
      held_valid <= 1'b1;
      held_word  <= want;
    end
  end

  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !hit) else $error("cache still hits after fault"); // R4

endmodule

// File: rtl/dbg_seq_ctrl.sv
module dbg_seq_ctrl
  import dbg_seq_pkg::*;
#(
  parameter logic [7:0] AP_NUM   = 8'h00,
  parameter logic [3:0] MEM_BANK = 4'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_valid,
  output logic              mem_ready,
  input  logic              mem_write,
  input  logic [WORD_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_wdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_err,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              xf_req,
  output logic              xf_ap,
  output logic              xf_rnw,
  output logic [1:0]        xf_addr,
  output logic [WORD_W-1:0] xf_wdata,
  input  logic              xf_done,
  input  logic [2:0]        xf_ack,
  input  logic [WORD_W-1:0] xf_rdata,
  input  logic              sel_hit,
  input  logic              retry_exhausted,
  output logic [WORD_W-1:0] sel_want,
  output logic              sel_store,
  output logic              sel_drop,
  output logic              retry_clear,
  output logic              retry_wait
);

  localparam logic [WORD_W-1:0] SEL_WORD = select_word(AP_NUM, MEM_BANK);

  step_e             state, state_nx;
  logic              r_write;
  logic [WORD_W-1:0] r_addr, r_wdata, r_rdata;
  res_e              r_res;
  xfer_t             cur;

  // named events
  logic issuing, ack_ok, ack_wait;
  logic ev_accept, ev_done, ev_ok, ev_retry, ev_timeout, ev_fault, ev_abort_done;

  assign issuing   = (state == STP_SEL) || (state == STP_TAR) || (state == STP_DRW) ||
                     (state == STP_RDBUF) || (state == STP_ABORT);
  assign ack_ok    = (xf_ack == ACK_OK);
  assign ack_wait  = (xf_ack == ACK_WAIT);

  assign ev_accept     = (state == STP_IDLE) && mem_valid;
  assign ev_done       = issuing && xf_done;
  assign ev_abort_done = ev_done && (state == STP_ABORT);
  assign ev_ok         = ev_done && (state != STP_ABORT) && ack_ok;
  assign ev_retry      = ev_done && (state != STP_ABORT) && ack_wait && !retry_exhausted;
  assign ev_timeout    = ev_done && (state != STP_ABORT) && ack_wait && retry_exhausted;
  assign ev_fault      = ev_done && (state != STP_ABORT) && !ack_ok && !ack_wait;

  assign sel_want    = SEL_WORD;
  assign sel_store   = ev_ok && (state == STP_SEL);
  assign sel_drop    = ev_fault;
  assign retry_wait  = ev_done && (state != STP_ABORT) && ack_wait;
  assign retry_clear = (state == STP_IDLE) || (ev_done && !ack_wait);

  always_comb begin
    state_nx = state;
    if (state == STP_IDLE) begin
      if (mem_valid) state_nx = sel_hit ? STP_TAR : STP_SEL;
    end else if (state == STP_RESP) begin
      state_nx = STP_IDLE;
    end else if (ev_abort_done || ev_timeout) begin
      state_nx = STP_RESP;
    end else if (ev_fault) begin
      state_nx = STP_ABORT;
    end else if (ev_ok) begin
      state_nx = step_after_ok(state, r_write);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= STP_IDLE;
      r_write <= 1'b0;
      r_addr  <= '0;
      r_wdata <= '0;
      r_rdata <= '0;
      r_res   <= RES_OK;
    end else begin
      state <= state_nx;
      if (ev_accept) begin
        r_write <= mem_write;
        r_addr  <= mem_addr;
        r_wdata <= mem_wdata;
        r_rdata <= '0;
        r_res   <= RES_OK;
      end
      if (ev_ok && state == STP_RDBUF) r_rdata <= xf_rdata;
      if (ev_timeout)                  r_res   <= RES_TIMEOUT;
      if (ev_fault)                    r_res   <= RES_FAULT;
    end
  end

  always_comb cur = build_xfer(state, r_write, r_addr, r_wdata, SEL_WORD);

  assign mem_ready = (state == STP_IDLE);
  assign xf_req    = issuing;
  assign xf_ap     = cur.ap;
  assign xf_rnw    = cur.rnw;
  assign xf_addr   = cur.a;
  assign xf_wdata  = cur.wdata;
  assign rsp_valid = (state == STP_RESP);
  assign rsp_err   = r_res;
  assign rsp_rdata = r_rdata;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ready |-> !xf_req) else $error("transfer while idle"); // R1

  AST_XF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xf_req && !xf_done) |=> (xf_req && $stable(xf_ap) && $stable(xf_rnw) &&
                              $stable(xf_addr) && $stable(xf_wdata))) else $error("fields moved"); // R8

  AST_RETRY_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retry |=> (xf_req && $stable(xf_addr) && $stable(xf_ap) && $stable(xf_rnw))) else $error("retry changed transfer"); // R5

  AST_TIMEOUT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> (rsp_valid && rsp_err == 2'b01 && !xf_req)) else $error("timeout not reported"); // R6

  AST_ABORT_FOLLOWS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> (xf_req && !xf_ap && !xf_rnw && xf_addr == 2'b00)) else $error("no abort after fault"); // R7

  AST_RESP_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (mem_ready && !rsp_valid)) else $error("response not single"); // R9

endmodule

// File: rtl/dbg_mem_seq.sv
module dbg_mem_seq
  import dbg_seq_pkg::*;
#(
  parameter logic [7:0] AP_NUM   = 8'h00,
  parameter logic [3:0] MEM_BANK = 4'h0,
  parameter int         RETRY_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RETRY_W-1:0] retry_limit,
  input  logic               mem_valid,
  output logic               mem_ready,
  input  logic               mem_write,
  input  logic [31:0]        mem_addr,
  input  logic [31:0]        mem_wdata,
  output logic               rsp_valid,
  output logic [1:0]         rsp_err,
  output logic [31:0]        rsp_rdata,
  output logic               xf_req,
  output logic               xf_ap,
  output logic               xf_rnw,
  output logic [1:0]         xf_addr,
  output logic [31:0]        xf_wdata,
  input  logic               xf_done,
  input  logic [2:0]         xf_ack,
  input  logic [31:0]        xf_rdata
);

  logic              sel_hit, sel_store, sel_drop;
  logic [WORD_W-1:0] sel_want;
  logic              retry_clear, retry_wait, retry_exhausted;
  logic [RETRY_W-1:0] retry_count;

  dbg_seq_ctrl #(.AP_NUM(AP_NUM), .MEM_BANK(MEM_BANK)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .xf_req(xf_req), .xf_ap(xf_ap), .xf_rnw(xf_rnw), .xf_addr(xf_addr), .xf_wdata(xf_wdata),
    .xf_done(xf_done), .xf_ack(xf_ack), .xf_rdata(xf_rdata),
    .sel_hit(sel_hit), .retry_exhausted(retry_exhausted),
    .sel_want(sel_want), .sel_store(sel_store), .sel_drop(sel_drop),
    .retry_clear(retry_clear), .retry_wait(retry_wait)
  );

  dbg_seq_bank_cache #(.WORD_W(WORD_W)) u_cache (
    .clk(clk), .rst_n(rst_n), .store(sel_store), .drop(sel_drop),
    .want(sel_want), .hit(sel_hit)
  );

  dbg_seq_retry #(.RETRY_W(RETRY_W)) u_retry (
    .clk(clk), .rst_n(rst_n), .clear(retry_clear), .wait_seen(retry_wait),
    .limit(retry_limit), .exhausted(retry_exhausted), .count(retry_count)
  );

  AST_SEL_BEFORE_AP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ready && mem_valid && !sel_hit) |=> (xf_req && !xf_ap && xf_addr == 2'b10)) else $error("select missing"); // R4

endmodule

// File: tb/sim_dbg_mem_seq.sv
module sim_dbg_mem_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  retry_limit = 8'd0;
  logic        mem_valid = 1'b0, mem_write = 1'b0;
  logic [31:0] mem_addr = '0, mem_wdata = '0;
  logic        mem_ready, rsp_valid;
  logic [1:0]  rsp_err;
  logic [31:0] rsp_rdata;
  logic        xf_req, xf_ap, xf_rnw;
  logic [1:0]  xf_addr;
  logic [31:0] xf_wdata;
  logic        xf_done = 1'b0;
  logic [2:0]  xf_ack = 3'b000;
  logic [31:0] xf_rdata = '0;

  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk; // 250 MHz

  dbg_mem_seq u0 (.*);

  // transfer log written by the engine model
  logic        lg_ap[64], lg_rnw[64];
  logic [1:0]  lg_a[64];
  logic [31:0] lg_wd[64];
  int          log_n = 0;
  logic [2:0]  script[16];
  int          script_len = 0, script_idx = 0;
  logic [31:0] rd_value = '0;
  bit          sel_known = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_sel_word();
    return 32'(8'h00) << 24; // default AP number and bank 0
  endfunction

  function automatic logic [31:0] exp_abort_word();
    return 32'd2 + 32'd4 + 32'd8 + 32'd16;
  endfunction

  task automatic chk_xf(int i, bit ap, bit rnw, logic [1:0] a, logic [31:0] wd, string req);
    bit ok;
    ok = (i < log_n) && lg_ap[i] == ap && lg_rnw[i] == rnw && lg_a[i] == a && lg_wd[i] == wd;
    chk(ok, req, {lg_ap[i], lg_rnw[i], 12'h0, 14'h0, lg_a[i]}, {ap, rnw, 12'h0, 14'h0, a});
    if (ok == 0) $display("  entry %0d wdata actual=%h expected=%h", i, lg_wd[i], wd);
  endtask

  // engine model
  initial begin
    forever begin
      @(negedge clk);
      if (xf_req) begin
        bit ap, rnw; logic [1:0] a; logic [31:0] wd; logic [2:0] ack; int lat;
        ap = xf_ap; rnw = xf_rnw; a = xf_addr; wd = xf_wdata;
        if (log_n < 64) begin
          lg_ap[log_n] = ap; lg_rnw[log_n] = rnw; lg_a[log_n] = a; lg_wd[log_n] = wd;
        end
        log_n++;
        lat = 1 + int'($urandom % 3);
        for (int k = 1; k < lat; k++) begin
          @(negedge clk);
          chk(xf_req && xf_ap == ap && xf_rnw == rnw && xf_addr == a && xf_wdata == wd,
              "R8", xf_wdata, wd);
        end
        ack = 3'b001;
        if (script_idx < script_len) begin ack = script[script_idx]; script_idx++; end
        xf_ack   = ack;
        xf_rdata = (!ap && rnw && a == 2'b11) ? rd_value : (32'hBAD0_0000 + 32'(log_n));
        xf_done  = 1'b1;
        @(negedge clk);
        xf_done = 1'b0;
        xf_ack  = 3'b000;
      end
    end
  end

  logic [1:0]  got_err;
  logic [31:0] got_rdata;

  task automatic do_op(bit wr, logic [31:0] addr, logic [31:0] wd);
    int guard;
    log_n = 0; script_idx = 0;
    @(negedge clk);
    mem_valid = 1'b1; mem_write = wr; mem_addr = addr; mem_wdata = wd;
    chk(mem_ready == 1'b1, "R1", 32'(mem_ready), 32'd1);
    @(negedge clk);
    mem_valid = 1'b0;
    chk(mem_ready == 1'b0, "R1", 32'(mem_ready), 32'd0);
    guard = 0;
    while (!rsp_valid && guard < 500) begin @(negedge clk); guard++; end
    got_err = rsp_err; got_rdata = rsp_rdata;
    @(negedge clk);
    chk(!rsp_valid && mem_ready, "R9", {30'h0, rsp_valid, mem_ready}, 32'd1);
    script_len = 0;
  endtask

  // expected transfer list for a clean request
  task automatic chk_clean(bit wr, logic [31:0] addr, logic [31:0] wd);
    int i = 0;
    int exp_n;
    exp_n = (sel_known ? 0 : 1) + (wr ? 2 : 3);
    chk(log_n == exp_n, wr ? "R3" : "R2", 32'(log_n), 32'(exp_n));
    if (!sel_known) begin chk_xf(0, 0, 0, 2'b10, exp_sel_word(), "R4"); i = 1; end
    chk_xf(i, 1, 0, 2'b01, addr, wr ? "R3" : "R2");
    chk_xf(i + 1, 1, !wr, 2'b11, wr ? wd : 32'h0, wr ? "R3" : "R2");
    if (!wr) begin
      chk_xf(i + 2, 0, 1, 2'b11, 32'h0, "R2");
      chk(got_rdata == rd_value, "R2", got_rdata, rd_value);
    end else chk(got_rdata == 32'h0, "R9", got_rdata, 32'h0);
    chk(got_err == 2'b00, "R9", 32'(got_err), 32'd0);
    sel_known = 1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(mem_ready && !xf_req && !rsp_valid, "R1", {29'h0, mem_ready, xf_req, rsp_valid}, 32'h4);
    rst_n = 1'b1;

    // R2 R4: first read carries the select write
    rd_value = 32'h1234_5678;
    do_op(0, 32'h2000_0010, 32'h0);
    chk_clean(0, 32'h2000_0010, 32'h0);

    // R3 R4: write without select rewrite
    do_op(1, 32'h0800_0400, 32'hA1B2_C3D4);
    chk_clean(1, 32'h0800_0400, 32'hA1B2_C3D4);

    // random mix
    for (int n = 0; n < 30; n++) begin
      bit wr; logic [31:0] ad, wd;
      wr = 1'($urandom); ad = $urandom & 32'hFFFF_FFFC; wd = $urandom; rd_value = $urandom;
      do_op(wr, ad, wd);
      chk_clean(wr, ad, wd);
    end

    // R5: three WAITs tolerated with limit 3
    retry_limit = 8'd3;
    script[0] = 3'b010; script[1] = 3'b010; script[2] = 3'b010; script_len = 3;
    do_op(1, 32'h0000_1000, 32'h5555_AAAA);
    chk(log_n == 5, "R5", 32'(log_n), 32'd5);
    for (int k = 0; k < 4; k++) chk_xf(k, 1, 0, 2'b01, 32'h0000_1000, "R5");
    chk_xf(4, 1, 0, 2'b11, 32'h5555_AAAA, "R5");
    chk(got_err == 2'b00, "R5", 32'(got_err), 32'd0);

    // R6: limit 2, three WAITs -> timeout
    retry_limit = 8'd2;
    script[0] = 3'b010; script[1] = 3'b010; script[2] = 3'b010; script_len = 3;
    do_op(0, 32'h0000_2000, 32'h0);
    chk(log_n == 3, "R6", 32'(log_n), 32'd3);
    chk(got_err == 2'b01, "R6", 32'(got_err), 32'd1);
    chk(got_rdata == 32'h0, "R9", got_rdata, 32'h0);

    // R6: limit 0, single WAIT -> timeout
    retry_limit = 8'd0;
    script[0] = 3'b010; script_len = 1;
    do_op(1, 32'h0000_3000, 32'h1);
    chk(log_n == 1, "R6", 32'(log_n), 32'd1);
    chk(got_err == 2'b01, "R6", 32'(got_err), 32'd1);

    // R7: FAULT on the data-register read
    script[0] = 3'b001; script[1] = 3'b100; script[2] = 3'b010; script_len = 3;
    do_op(0, 32'h0000_4000, 32'h0);
    chk(log_n == 3, "R7", 32'(log_n), 32'd3);
    chk_xf(2, 0, 0, 2'b00, exp_abort_word(), "R7");
    chk(got_err == 2'b10, "R7", 32'(got_err), 32'd2);
    chk(got_rdata == 32'h0, "R9", got_rdata, 32'h0);
    sel_known = 0;

    // R4: select rewritten after the fault
    rd_value = 32'hCAFE_F00D;
    do_op(0, 32'h0000_5000, 32'h0);
    chk_clean(0, 32'h0000_5000, 32'h0);

    // R7: unknown acknowledge code treated as a fault
    script[0] = 3'b111; script_len = 1;
    do_op(1, 32'h0000_6000, 32'h77);
    chk(log_n == 2, "R7", 32'(log_n), 32'd2);
    chk_xf(1, 0, 0, 2'b00, exp_abort_word(), "R7");
    chk(got_err == 2'b10, "R7", 32'(got_err), 32'd2);
    sel_known = 0;

    do_op(1, 32'h0000_7000, 32'h0102_0304);
    chk_clean(1, 32'h0000_7000, 32'h0102_0304);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule